// File: doc/BRIEF.md
# Control Bus Command Parser (Slave Side)

This block sits behind a byte receiver on a small control bus and turns the byte stream into register accesses. Each command opens with a header byte holding a 3-bit device address, a 4-bit index and a 1-bit control flag. One or two further bytes follow, depending on the index. Commands whose address matches the strapped device address update or read an internal register file. Read commands are answered with a single response byte. Other commands are consumed silently.

A direct index reaches one of fourteen short registers. The all-ones index opens a second, extended register space, which is addressed through an 8-bit index byte that follows the header. The all-zeros index with the control flag set is a soft reset that clears every register. A start-of-command strobe marks the header byte. It also discards any partly received command, so the host can always resynchronise.

Top module: `ctlbus_cmd_parser`

## Requirements
- R1: After reset `rsp_vld` is 0 and every normal and extended register reads back as 0.
- R2: The header byte is laid out as bit 7 = control flag (1 write, 0 read), bits 6:3 = index, bits 2:0 = device address. A command never answers on its header byte.
- R3: A header with index 1..14 and a matching address is a 2-byte command. On a write, the second byte is stored into normal register `index`, and a later read returns that value.
- R4: A read produces `rsp_vld` = 1 for exactly one cycle, in the cycle after the last command byte is accepted. `rsp_data` then carries the addressed register, and `rsp_vld` is 0 at all other times.
- R5: Index 15 makes a 3-byte command in which byte 2 is an extended index and byte 3 is the payload. Extended indices below `EXT_DEPTH` are stored. At or above `EXT_DEPTH`, writes are ignored and reads return 0.
- R6: When the header address differs from `dev_addr`, the remaining command bytes are consumed. No register changes and no response is produced.
- R7: Index 0 with the control flag at 1 is a 2-byte soft reset. It clears all normal and extended registers and gives no response.
- R8: Index 0 with the control flag at 0 is a 2-byte command with no effect and no response.
- R9: A byte accepted together with `sof` is always taken as a header. A lone `sof` pulse returns the parser to wait for a header. In both cases any unfinished command is discarded without effect.
- R10: The normal and extended spaces are separate, so writing one never changes the other.
- R11: Cycles with `byte_vld` low do not advance the parser, and a byte accepted while waiting for a header is a header even without `sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_addr | input | 3 | Strapped device address |
| sof | input | 1 | Start-of-command strobe |
| byte_vld | input | 1 | Incoming byte valid |
| byte_data | input | 8 | Incoming byte |
| rsp_vld | output | 1 | Response byte valid (one-cycle pulse) |
| rsp_data | output | 8 | Response byte |

## Verification
If the sequencer is off by one state, every following command frame is misaligned. A payload then lands where a header is expected, and the next read back returns a wrong value, a missing response or an extra response within the following command. A wrong decode of the address, index or flag shows up as a stray or missing `rsp_vld` pulse at the end of that same command. A register written to the wrong place is exposed by the full read-back sweeps of both spaces, which are run after each phase of writes.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int DEV_W  = 3;
  localparam int NREG   = (1 << IDX_W) - 2;

  localparam logic [IDX_W-1:0] IDX_SPECIAL = '0;
  localparam logic [IDX_W-1:0] IDX_EXTEND  = '1;

  typedef enum logic [1:0] {ST_HDR = 2'd0, ST_B2 = 2'd1, ST_B3 = 2'd2} pstate_t;
  typedef enum logic [1:0] {K_NORM = 2'd0, K_EXT = 2'd1, K_SRST = 2'd2, K_NOP = 2'd3} kind_t;

  typedef struct packed {
    logic             wr;
    logic [IDX_W-1:0] idx;
    logic [DEV_W-1:0] dev;
  } hdr_t;
endpackage

// File: rtl/ctlbus_hdr_decode.sv
module ctlbus_hdr_decode
  import ctlbus_pkg::*;
(
  input  logic [BYTE_W-1:0] hdr_byte,
  input  logic [DEV_W-1:0]  dev_addr,
  output kind_t             kind,
  output logic              hit,
  output logic              wr,
  output logic [IDX_W-1:0]  idx
);
  hdr_t h;
  assign h   = hdr_t'(hdr_byte);
  assign hit = (h.dev == dev_addr);
  assign wr  = h.wr;
  assign idx = h.idx;

  always_comb begin
    if (h.idx == IDX_EXTEND)       kind = K_EXT;
    else if (h.idx == IDX_SPECIAL) kind = h.wr ? K_SRST : K_NOP;
    else                           kind = K_NORM;
  end
endmodule

// File: rtl/ctlbus_seq.sv
module ctlbus_seq
  import ctlbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output pstate_t           st,
  output kind_t             kind_q,
  output logic              hit_q,
  output logic              wr_q,
  output logic [BYTE_W-1:0] acc_addr,
  output logic              fin
);
  kind_t            dec_kind;
  logic             dec_hit, dec_wr;
  logic [IDX_W-1:0] dec_idx;

  ctlbus_hdr_decode u_dec (
    .hdr_byte(byte_data), .dev_addr(dev_addr),
    .kind(dec_kind), .hit(dec_hit), .wr(dec_wr), .idx(dec_idx)
  );

  pstate_t           st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] eidx_q;
  logic              hdr_en, eidx_en;

  always_comb begin
    hdr_en  = byte_vld && (sof || st_q == ST_HDR);
    eidx_en = byte_vld && !sof && st_q == ST_B2 && kind_q == K_EXT;
    fin     = byte_vld && !sof &&
              ((st_q == ST_B2 && kind_q != K_EXT) || st_q == ST_B3);
    st_d    = st_q;
    if (sof) begin
      st_d = byte_vld ? ST_B2 : ST_HDR;
    end else if (byte_vld) begin
      case (st_q)
        ST_HDR:  st_d = ST_B2;
        ST_B2:   st_d = (kind_q == K_EXT) ? ST_B3 : ST_HDR;
        default: st_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      kind_q <= K_NOP;
      hit_q  <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      eidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (hdr_en) begin
        kind_q <= dec_kind;
        hit_q  <= dec_hit;
        wr_q   <= dec_wr;
        idx_q  <= dec_idx;
      end
      if (eidx_en) eidx_q <= byte_data;
    end
  end

  assign st       = st_q;
  assign acc_addr = (kind_q == K_EXT) ? eidx_q : {{(BYTE_W-IDX_W){1'b0}}, idx_q};
endmodule

// File: rtl/ctlbus_regs.sv
module ctlbus_regs
  import ctlbus_pkg::*;
#(
  parameter int EXT_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic              ext,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] nrm_q [NREG];
  logic [BYTE_W-1:0] ext_q [EXT_DEPTH];

  for (genvar i = 0; i < NREG; i++) begin : g_nrm
    logic en;
    assign en = clr || (we && !ext && addr == BYTE_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  nrm_q[i] <= '0;
      else if (en) nrm_q[i] <= clr ? '0 : wdata;
    end
  end

  for (genvar j = 0; j < EXT_DEPTH; j++) begin : g_ext
    logic en;
    assign en = clr || (we && ext && addr == BYTE_W'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ext_q[j] <= '0;
      else if (en) ext_q[j] <= clr ? '0 : wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (!ext && addr == BYTE_W'(i + 1)) rdata = nrm_q[i];
    for (int j = 0; j < EXT_DEPTH; j++)
      if (ext && addr == BYTE_W'(j)) rdata = ext_q[j];
  end
endmodule

// File: rtl/ctlbus_cmd_parser.sv
module ctlbus_cmd_parser
  import ctlbus_pkg::*;
#(
  parameter int EXT_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              rsp_vld,
  output logic [BYTE_W-1:0] rsp_data
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pstate_t           st_w;
  kind_t             kind_w;
  logic              hit_w, wr_w, fin_w;
  logic [BYTE_W-1:0] acc_addr, rdata;
  logic              data_cmd, do_wr, do_rd, do_clr;

  ctlbus_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .dev_addr(dev_addr), .sof(sof),
    .byte_vld(byte_vld), .byte_data(byte_data), .st(st_w), .kind_q(kind_w),
    .hit_q(hit_w), .wr_q(wr_w), .acc_addr(acc_addr), .fin(fin_w)
  );

  assign data_cmd = (kind_w == K_NORM) || (kind_w == K_EXT);
  assign do_wr    = fin_w && hit_w && wr_w && data_cmd;
  assign do_rd    = fin_w && hit_w && !wr_w && data_cmd;
  assign do_clr   = fin_w && hit_w && kind_w == K_SRST;

  ctlbus_regs #(.EXT_DEPTH(EXT_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .clr(do_clr), .we(do_wr),
    .ext(kind_w == K_EXT), .addr(acc_addr), .wdata(byte_data), .rdata(rdata)
  );

  logic              rsp_vld_q;
  logic [BYTE_W-1:0] rsp_data_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_vld_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      rsp_vld_q <= do_rd;
      if (do_rd) rsp_data_q <= rdata;
    end
  end

  assign rsp_vld  = rsp_vld_q;
  assign rsp_data = rsp_data_q;
endmodule

// File: rtl/ctlbus_parser_chk.sv
module ctlbus_parser_chk
  import ctlbus_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sof,
  input logic    byte_vld,
  input logic    rsp_vld,
  input pstate_t st,
  input kind_t   kind,
  input logic    hit
);
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |=> !rsp_vld);

  p_rsp_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> ($past(byte_vld) && !$past(sof)));

  p_rsp_not_on_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> ($past(st) != ST_HDR));

  p_rsp_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(hit));

  p_b3_only_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B3) |-> (kind == K_EXT));

  p_sof_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (st == ($past(byte_vld) ? ST_B2 : ST_HDR)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !sof) |=> $stable(st));
endmodule

bind ctlbus_cmd_parser ctlbus_parser_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sof(sof), .byte_vld(byte_vld),
  .rsp_vld(rsp_vld), .st(st_w), .kind(kind_w), .hit(hit_w)
);

// File: tb/ctlbus_cmd_parser_test.sv
module ctlbus_cmd_parser_test;
  localparam int XD  = 16;
  localparam logic [2:0] DEV = 3'b110;

  logic       clk = 1'b0;
  logic       rst_n, sof, byte_vld;
  logic [2:0] dev_addr;
  logic [7:0] byte_data, rsp_data;
  logic       rsp_vld;

  int vectors = 0;
  int fails   = 0;

  logic [7:0] m_nrm [1:14];
  logic [7:0] m_ext [XD];

  always #10 clk = ~clk;

  ctlbus_cmd_parser #(.EXT_DEPTH(XD)) uut (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sof(sof),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr(input bit c, input logic [3:0] ix, input logic [2:0] a);
    return {c, ix, a};
  endfunction

  task automatic send(input logic [7:0] b, input bit s, input int gap);
    repeat (gap) @(negedge clk);
    byte_vld = 1'b1; byte_data = b; sof = s;
    @(negedge clk);
    byte_vld = 1'b0; sof = 1'b0; byte_data = 8'h00;
  endtask

  // Header, optional extended index, payload. Returns response seen after last byte.
  task automatic cmd(input logic [7:0] h, input bit ext, input logic [7:0] ei,
                     input logic [7:0] pay, input int gap, input bit use_sof,
                     output bit gv, output logic [7:0] gd);
    send(h, use_sof, gap);
    chk(rsp_vld == 1'b0, "R2 no response on header", rsp_vld, 0);
    if (ext) begin
      send(ei, 1'b0, gap);
      chk(rsp_vld == 1'b0, "R5 no response on ext index", rsp_vld, 0);
    end
    send(pay, 1'b0, gap);
    gv = rsp_vld; gd = rsp_data;
    @(negedge clk);
    chk(rsp_vld == 1'b0, "R4 response lasts one cycle", rsp_vld, 0);
  endtask

  task automatic wr_n(input int i, input logic [7:0] v, input logic [2:0] a);
    bit gv; logic [7:0] gd;
    cmd(hdr(1'b1, 4'(i), a), 1'b0, 8'h00, v, 0, 1'b1, gv, gd);
    chk(gv == 1'b0, "R3 write gives no response", gv, 0);
  endtask

  task automatic wr_x(input int e, input logic [7:0] v, input logic [2:0] a);
    bit gv; logic [7:0] gd;
    cmd(hdr(1'b1, 4'hF, a), 1'b1, 8'(e), v, 0, 1'b1, gv, gd);
    chk(gv == 1'b0, "R5 ext write gives no response", gv, 0);
  endtask

  task automatic rd_n(input int i, input string req);
    bit gv; logic [7:0] gd;
    cmd(hdr(1'b0, 4'(i), DEV), 1'b0, 8'h00, 8'h3C, 0, 1'b1, gv, gd);
    chk(gv == 1'b1, {req, " R4 read responds"}, gv, 1);
    chk(gd == m_nrm[i], {req, " R3 normal read data"}, gd, m_nrm[i]);
  endtask

  task automatic rd_x(input int e, input string req);
    bit gv; logic [7:0] gd; logic [7:0] ex;
    ex = (e < XD) ? m_ext[e] : 8'h00;
    cmd(hdr(1'b0, 4'hF, DEV), 1'b1, 8'(e), 8'hC3, 0, 1'b1, gv, gd);
    chk(gv == 1'b1, {req, " R4 ext read responds"}, gv, 1);
    chk(gd == ex, {req, " R5 ext read data"}, gd, ex);
  endtask

  task automatic sweep_all(input string req);
    for (int i = 1; i <= 14; i++) rd_n(i, req);
    for (int e = 0; e < XD; e++) rd_x(e, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit gv; logic [7:0] gd;
    rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; byte_data = 8'h00; dev_addr = DEV;
    for (int i = 1; i <= 14; i++) m_nrm[i] = 8'h00;
    for (int e = 0; e < XD; e++) m_ext[e] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rsp_vld == 1'b0, "R1 rsp_vld low after reset", rsp_vld, 0);
    sweep_all("R1 reset zero");

    // R3/R2: two passes of normal writes with distinct patterns
    for (int k = 0; k < 2; k++) begin
      for (int i = 1; i <= 14; i++) begin
        m_nrm[i] = 8'((i * 37 + k * 91 + 5) & 255);
        wr_n(i, m_nrm[i], DEV);
      end
      for (int i = 1; i <= 14; i++) rd_n(i, "R3 sweep");
    end

    // R5: every extended index; only those below XD are stored
    for (int e = 0; e < 256; e++) begin
      if (e < XD) m_ext[e] = 8'((e * 13) ^ 8'hA5);
      wr_x(e, 8'((e * 13) ^ 8'hA5), DEV);
    end
    for (int e = 0; e < 256; e++) rd_x(e, "R5 sweep");
    // R10: normal space untouched by extended writes
    for (int i = 1; i <= 14; i++) rd_n(i, "R10 separate spaces");

    // R6: every foreign address: writes and reads silent
    for (int a = 0; a < 8; a++) begin
      if (3'(a) == DEV) continue;
      wr_n(3, 8'h5A, 3'(a));
      wr_x(2, 8'h5A, 3'(a));
      cmd(hdr(1'b0, 4'd3, 3'(a)), 1'b0, 8'h00, 8'h00, 0, 1'b1, gv, gd);
      chk(gv == 1'b0, "R6 mismatch read silent", gv, 0);
      cmd(hdr(1'b0, 4'hF, 3'(a)), 1'b1, 8'd2, 8'h00, 0, 1'b1, gv, gd);
      chk(gv == 1'b0, "R6 mismatch ext read silent", gv, 0);
      cmd(hdr(1'b1, 4'd0, 3'(a)), 1'b0, 8'h00, 8'h00, 0, 1'b1, gv, gd);
      chk(gv == 1'b0, "R6 mismatch soft reset silent", gv, 0);
    end
    sweep_all("R6 unchanged");

    // R8: reserved special code
    cmd(hdr(1'b0, 4'd0, DEV), 1'b0, 8'h00, 8'hFF, 0, 1'b1, gv, gd);
    chk(gv == 1'b0, "R8 reserved code silent", gv, 0);
    sweep_all("R8 unchanged");

    // R9: sof with a byte aborts a pending write
    send(hdr(1'b1, 4'd5, DEV), 1'b1, 0);
    send(hdr(1'b0, 4'd5, DEV), 1'b1, 0);
    send(8'h77, 1'b0, 0);
    chk(rsp_vld == 1'b1, "R9 restarted read responds", rsp_vld, 1);
    chk(rsp_data == m_nrm[5], "R9 aborted write discarded", rsp_data, m_nrm[5]);
    @(negedge clk);
    // R9: lone sof aborts an extended write after its index byte
    send(hdr(1'b1, 4'hF, DEV), 1'b1, 0);
    send(8'd2, 1'b0, 0);
    sof = 1'b1; @(negedge clk); sof = 1'b0;
    send(hdr(1'b0, 4'd7, DEV), 1'b0, 0);
    send(8'hEE, 1'b0, 0);
    chk(rsp_vld == 1'b1, "R9 header after lone sof", rsp_vld, 1);
    chk(rsp_data == m_nrm[7], "R9 header after lone sof data", rsp_data, m_nrm[7]);
    @(negedge clk);
    rd_x(2, "R9 ext abort");

    // R11: idle gaps and headers without sof
    m_nrm[9] = 8'hD2;
    cmd(hdr(1'b1, 4'd9, DEV), 1'b0, 8'h00, 8'hD2, 3, 1'b0, gv, gd);
    chk(gv == 1'b0, "R11 gapped write silent", gv, 0);
    m_ext[11] = 8'h4B;
    cmd(hdr(1'b1, 4'hF, DEV), 1'b1, 8'd11, 8'h4B, 2, 1'b0, gv, gd);
    cmd(hdr(1'b0, 4'hF, DEV), 1'b1, 8'd11, 8'h00, 4, 1'b0, gv, gd);
    chk(gv == 1'b1 && gd == 8'h4B, "R11 gapped ext read", {gv, gd}, {1'b1, 8'h4B});
    cmd(hdr(1'b0, 4'd9, DEV), 1'b0, 8'h00, 8'h00, 5, 1'b0, gv, gd);
    chk(gv == 1'b1 && gd == 8'hD2, "R11 gapped read", {gv, gd}, {1'b1, 8'hD2});

    // R7: soft reset clears everything
    cmd(hdr(1'b1, 4'd0, DEV), 1'b0, 8'h00, 8'h99, 0, 1'b1, gv, gd);
    chk(gv == 1'b0, "R7 soft reset silent", gv, 0);
    for (int i = 1; i <= 14; i++) m_nrm[i] = 8'h00;
    for (int e = 0; e < XD; e++) m_ext[e] = 8'h00;
    sweep_all("R7 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule